// File: doc/BRIEF.md
# Bus Master Latency Timer

This block caps how long a bus master may keep bursting on a shared parallel bus once it has started a transaction. Software programs an 8-bit configuration register. Its upper five bits hold a burst allowance counted in units of eight bus clocks. Its lower three bits are reserved. When the master signals the start of a transaction, the block loads a down-counter with that allowance. The counter then steps down once per clock while the transfer is in progress.

Reaching zero does not by itself end the burst. The block asks the master to end its cycle only when the counter has run out and the arbiter has also taken the grant away. While the grant is still held, the master may stay on the bus for as long as it likes. The terminate request is held until the transfer ends, and a new transaction start clears it.

Top module: `bus_latency_timer`

## Requirements
- R1: When `cfg_we` is high at a clock edge, `cfg_rdata[7:3]` shows `cfg_wdata[7:3]` from the next cycle on, and keeps that value until the next write.
- R2: `cfg_rdata[2:0]` always reads 0, whatever was written to those bit positions.
- R3: While `rst_n` is low at a clock edge, the next cycle shows `cfg_rdata` = 00h, `term_req` = 0 and `expired` = 1, because the counter is zero.
- R4: A clock edge with `frame_start` high loads the counter with `cfg_rdata[7:3]` × 8. Each later edge with `xfer_active` high and the counter non-zero lowers it by one. Edges with `xfer_active` low leave it unchanged. `expired` is high exactly while the counter is zero, so for a count N > 0 it rises after the 8·N-th active edge.
- R5: If the count field is zero at the `frame_start` edge, `expired` is high in the very next cycle.
- R6: An edge where `expired` = 1, `gnt` = 0, `xfer_active` = 1 and `frame_start` = 0 makes `term_req` high in the next cycle.
- R7: An edge with `gnt` high never raises `term_req` from low, so expiry while the grant is held raises no request.
- R8: Once high, `term_req` stays high on every edge where `xfer_active` is high and `frame_start` is low, even if `gnt` comes back. It is low in the cycle after any edge where `xfer_active` is low.
- R9: An edge with `frame_start` high clears `term_req` in the next cycle and reloads the counter. This takes priority over holding, setting or counting.
- R10: A register write during a countdown does not change that countdown. When a write and `frame_start` fall on the same edge, the counter loads the count field that was in the register before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data; bits 7:3 are the count, bits 2:0 are ignored |
| frame_start | input | 1 | One-clock pulse when the master begins a transaction |
| gnt | input | 1 | Arbiter grant level; high means the master still owns the bus |
| xfer_active | input | 1 | High while the master's transfer is in progress |
| cfg_rdata | output | 8 | Register readback |
| expired | output | 1 | High while the down-counter is zero |
| term_req | output | 1 | Request to the master to end its cycle |

## Verification
Directed runs use nonzero counts with the grant held through expiry and dropped afterwards, which separates "expired" from "terminate". A run where the transfer pauses partway through shows that only active clocks are counted. A zero count checks immediate expiry. Writes placed in the middle of a countdown, or on the same edge as a frame start, separate the snapshot value from the live register value. Random sequences of writes, frame starts, grant drops and transfer pauses are then compared every cycle against a bench model, which tests the priority among reload, clear and hold.

// File: rtl/blt_pkg.sv
// Package: shared defaults for the bus master latency timer.
// Assumes: the register is REG_W bits wide; its low UNIT_LOG2 bits are reserved
// and the count unit is 2**UNIT_LOG2 clocks.
package blt_pkg;
    localparam int unsigned DEF_REG_W     = 8;
    localparam int unsigned DEF_UNIT_LOG2 = 3;
endpackage

// File: rtl/lat_cfg_reg.sv
// Module: lat_cfg_reg
// Holds the writable count field of the configuration register and forms the
// readback with the reserved low bits forced to zero.
// Assumes: writes are single-cycle strobes; reserved write bits are dropped upstream.
module lat_cfg_reg #(
    parameter int unsigned REG_W     = blt_pkg::DEF_REG_W,
    parameter int unsigned UNIT_LOG2 = blt_pkg::DEF_UNIT_LOG2,
    localparam int unsigned FLD_W    = REG_W - UNIT_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [FLD_W-1:0] field_wr_i,
    output logic [FLD_W-1:0] field_o,
    output logic [REG_W-1:0] rdata_o
);
    logic [FLD_W-1:0] field_q;

    // Capture the count field on a write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            field_q <= '0;
        else if (we_i)
            field_q <= field_wr_i;
    end

    // Readback: count field above reserved zero bits.
    always_comb begin
        rdata_o = {field_q, {UNIT_LOG2{1'b0}}};
    end

    assign field_o = field_q;
endmodule

// File: rtl/lat_down_counter.sv
// Module: lat_down_counter
// Loads field*2**UNIT_LOG2 on a frame start, decrements on active clocks,
// and stops at zero. Reports zero as the expiry flag.
// Assumes: load_i has priority over run_i.
module lat_down_counter #(
    parameter int unsigned REG_W     = blt_pkg::DEF_REG_W,
    parameter int unsigned UNIT_LOG2 = blt_pkg::DEF_UNIT_LOG2,
    localparam int unsigned FLD_W    = REG_W - UNIT_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [FLD_W-1:0] field_i,
    input  logic             run_i,
    output logic             zero_o
);
    logic [REG_W-1:0] cnt_q;
    logic [REG_W-1:0] load_val;

    // Scale the programmed field to clocks.
    always_comb begin
        load_val = {field_i, {UNIT_LOG2{1'b0}}};
    end

    // Reload on frame start, otherwise step down while running until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val;
        else if (run_i && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lat_term_ctl.sv
// Module: lat_term_ctl
// Raises the terminate request when the timer has expired and the grant is
// gone, holds it through the rest of the transfer, and clears it on a new
// frame or when the transfer ends.
// Assumes: expired_i comes from a register, so the request follows one clock later.
module lat_term_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start_i,
    input  logic gnt_i,
    input  logic active_i,
    input  logic expired_i,
    output logic term_o
);
    logic term_q;

    // Sticky terminate request with clear priority: reset, frame, transfer end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            term_q <= 1'b0;
        else if (frame_start_i || !active_i)
            term_q <= 1'b0;
        else if (expired_i && !gnt_i)
            term_q <= 1'b1;
    end

    assign term_o = term_q;
endmodule

// File: rtl/bus_latency_timer.sv
// Module: bus_latency_timer (top)
// Limits a bus master's burst length. It combines the configuration register,
// the scaled down-counter and the terminate control.
// Assumes: frame_start is a one-clock pulse; gnt and xfer_active are synchronous.
module bus_latency_timer #(
    parameter int unsigned REG_W     = blt_pkg::DEF_REG_W,
    parameter int unsigned UNIT_LOG2 = blt_pkg::DEF_UNIT_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             frame_start,
    input  logic             gnt,
    input  logic             xfer_active,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             expired,
    output logic             term_req
);
    localparam int unsigned FLD_W = REG_W - UNIT_LOG2;

    logic [FLD_W-1:0] field;
    logic             unused_rsvd_wr;

    assign unused_rsvd_wr = ^cfg_wdata[UNIT_LOG2-1:0];

    lat_cfg_reg #(.REG_W(REG_W), .UNIT_LOG2(UNIT_LOG2)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we),
        .field_wr_i (cfg_wdata[REG_W-1:UNIT_LOG2]),
        .field_o    (field),
        .rdata_o    (cfg_rdata)
    );

    lat_down_counter #(.REG_W(REG_W), .UNIT_LOG2(UNIT_LOG2)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (frame_start),
        .field_i (field),
        .run_i   (xfer_active),
        .zero_o  (expired)
    );

    lat_term_ctl term_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start),
        .gnt_i         (gnt),
        .active_i      (xfer_active),
        .expired_i     (expired),
        .term_o        (term_req)
    );
endmodule

// File: rtl/blt_checker.sv
// Module: blt_checker
// Port-level temporal checks for bus_latency_timer, attached with bind.
module blt_checker #(
    parameter int unsigned REG_W     = 8,
    parameter int unsigned UNIT_LOG2 = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [REG_W-1:0] cfg_wdata,
    input logic             frame_start,
    input logic             gnt,
    input logic             xfer_active,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             expired,
    input logic             term_req
);
    localparam logic [REG_W-1:0] FLD_MASK = {{(REG_W-UNIT_LOG2){1'b1}}, {UNIT_LOG2{1'b0}}};

    // R1
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == ($past(cfg_wdata) & FLD_MASK));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[UNIT_LOG2-1:0] == '0);

    // R3
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cfg_rdata == '0) && !term_req && expired);

    // R4
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && (cfg_rdata != '0)) |=> !expired);

    // R5
    load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && (cfg_rdata == '0)) |=> expired);

    // R6
    term_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !gnt && xfer_active && !frame_start) |=> term_req);

    // R7
    gnt_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && !term_req) |=> !term_req);

    // R8
    term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_req && xfer_active && !frame_start) |=> term_req);

    // R8
    term_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> !term_req);

    // R9
    frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !term_req);
endmodule

bind bus_latency_timer blt_checker #(.REG_W(REG_W), .UNIT_LOG2(UNIT_LOG2)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .frame_start (frame_start),
    .gnt         (gnt),
    .xfer_active (xfer_active),
    .cfg_rdata   (cfg_rdata),
    .expired     (expired),
    .term_req    (term_req)
);

// File: tb/bus_latency_timer_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random stimulus, compared
// every cycle against a model built from the requirements.
module bus_latency_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic       frame_start;
    logic       gnt;
    logic       xfer_active;
    logic [7:0] cfg_rdata;
    logic       expired;
    logic       term_req;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Model state
    logic [7:0] m_reg, m_cnt;
    logic       m_term;

    always #2 clk = ~clk;

    bus_latency_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .frame_start(frame_start), .gnt(gnt), .xfer_active(xfer_active),
        .cfg_rdata(cfg_rdata), .expired(expired), .term_req(term_req)
    );

    function automatic logic [7:0] nxt_cnt(logic [7:0] c, logic [7:0] r, logic fs, logic act);
        if (fs)                  return r & 8'hF8;
        if (act && (c != 8'h00)) return c - 8'h01;
        return c;
    endfunction

    function automatic logic nxt_term(logic t, logic c_zero, logic fs, logic act, logic g);
        if (fs || !act)    return 1'b0;
        if (c_zero && !g)  return 1'b1;
        return t;
    endfunction

    task automatic check(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // Advance one clock, update the model, compare at the falling edge.
    task automatic tick(input string tag);
        logic [7:0] nr, nc;
        logic       nt;
        @(posedge clk);
        if (!rst_n) begin
            nr = 8'h00; nc = 8'h00; nt = 1'b0;
        end else begin
            nr = cfg_we ? (cfg_wdata & 8'hF8) : m_reg;
            nc = nxt_cnt(m_cnt, m_reg, frame_start, xfer_active);
            nt = nxt_term(m_term, m_cnt == 8'h00, frame_start, xfer_active, gnt);
        end
        m_reg = nr; m_cnt = nc; m_term = nt;
        @(negedge clk);
        check({"R1,R2 readback ", tag}, cfg_rdata, m_reg);
        check({"expired ", tag}, {7'd0, expired}, {7'd0, m_cnt == 8'h00});
        check({"term_req ", tag}, {7'd0, term_req}, {7'd0, m_term});
    endtask

    task automatic idle();
        cfg_we = 1'b0; frame_start = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] v, input string tag);
        cfg_we = 1'b1; cfg_wdata = v;
        tick(tag);
        cfg_we = 1'b0;
    endtask

    task automatic start_frame(input string tag);
        frame_start = 1'b1; xfer_active = 1'b1;
        tick(tag);
        frame_start = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int k;
        void'($urandom(32'd20240611));
        m_reg = 8'h00; m_cnt = 8'h00; m_term = 1'b0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00;
        frame_start = 1'b0; gnt = 1'b1; xfer_active = 1'b0;
        @(negedge clk);
        tick("R3");
        tick("R3");
        check("R3 rdata after reset", cfg_rdata, 8'h00);
        check("R3 expired after reset", {7'd0, expired}, 8'h01);
        check("R3 term after reset", {7'd0, term_req}, 8'h00);
        rst_n = 1'b1;

        // R1 / R2: reserved bits read zero
        write_reg(8'hFF, "R1");
        check("R2 reserved bits", cfg_rdata, 8'hF8);
        write_reg(8'h1D, "R1");
        check("R1 count field", cfg_rdata, 8'h18);

        // R4 / R7: count 3 expires after 24 active clocks, grant held
        gnt = 1'b1;
        start_frame("R4");
        k = 0;
        while (!expired && k < 100) begin tick("R4"); k++; end
        check("R4 clocks to expiry N=3", k[7:0], 8'd24);
        repeat (5) tick("R7");
        check("R7 no term with grant", {7'd0, term_req}, 8'h00);
        // R6: drop grant, request next clock
        gnt = 1'b0;
        tick("R6");
        check("R6 term after grant drop", {7'd0, term_req}, 8'h01);
        // R8: grant returns, request holds; transfer ends, request drops
        gnt = 1'b1;
        repeat (3) tick("R8");
        check("R8 term holds", {7'd0, term_req}, 8'h01);
        xfer_active = 1'b0;
        tick("R8");
        check("R8 term clears at end", {7'd0, term_req}, 8'h00);

        // R4: paused transfer holds the count
        write_reg(8'h10, "R4");
        start_frame("R4");
        repeat (5) tick("R4");
        xfer_active = 1'b0;
        repeat (10) tick("R4");
        check("R4 paused not expired", {7'd0, expired}, 8'h00);
        xfer_active = 1'b1;
        k = 0;
        while (!expired && k < 100) begin tick("R4"); k++; end
        check("R4 remaining after pause", k[7:0], 8'd11);

        // R5: zero count expires at once
        write_reg(8'h07, "R5");
        gnt = 1'b0;
        start_frame("R5");
        check("R5 immediate expiry", {7'd0, expired}, 8'h01);
        tick("R5");
        check("R5 term with zero count", {7'd0, term_req}, 8'h01);

        // R9: frame start clears request and reloads
        write_reg(8'h20, "R9");
        check("R9 term still set", {7'd0, term_req}, 8'h01);
        start_frame("R9");
        check("R9 term cleared", {7'd0, term_req}, 8'h00);
        check("R9 reloaded", {7'd0, expired}, 8'h00);

        // R10: write mid-countdown does not alter it
        gnt = 1'b1;
        repeat (4) tick("R10");
        write_reg(8'h08, "R10");
        k = 5;
        while (!expired && k < 100) begin tick("R10"); k++; end
        check("R10 mid-run write ignored", k[7:0], 8'd32);
        // R10: write on same edge as frame start uses old value (N=1)
        cfg_we = 1'b1; cfg_wdata = 8'h30;
        start_frame("R10");
        cfg_we = 1'b0;
        k = 0;
        while (!expired && k < 100) begin tick("R10"); k++; end
        check("R10 same-edge write uses old", k[7:0], 8'd8);
        xfer_active = 1'b0;
        tick("R8");

        // Random mix compared to the model every cycle
        for (int i = 0; i < 4000; i++) begin
            cfg_we      = ($urandom % 10) == 0;
            cfg_wdata   = 8'($urandom);
            if (($urandom % 4) == 0) cfg_wdata = cfg_wdata & 8'h0F;
            frame_start = ($urandom % 30) == 0;
            gnt         = ($urandom % 10) < 6;
            xfer_active = ($urandom % 10) < 9;
            rst_n       = ($urandom % 1000) != 0;
            tick("R6 random");
        end
        rst_n = 1'b1;
        idle();
        tick("R9 random end");
        finish_run();
    end
endmodule